// File: doc/BRIEF.md
# Interprocessor Interrupt Command Dispatcher

A processor uses this block to send interrupt messages to other cores, up to `NCORES` of them. The block holds a 64-bit command register that is split into two 32-bit words at fixed offsets. A write to the lower word fixes the message kind, the vector, the addressing mode and the target shorthand, and it starts a send. A write to the upper word sets only the 8-bit destination.

When a send starts, the block works out the set of receiving cores. It uses one of three methods: the shorthand, a match against each core's physical ID, or a bitmask overlap with each core's logical ID. For the lowest-priority kind it then narrows that set to the single candidate whose 4-bit priority input is smallest. It issues a one-cycle request pulse per target, together with a shared kind code, vector, level and trigger. The pending status bit stays set until every target has returned an acknowledge.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset, both register words read as zero and no request is driven.
- R2: The lower word reads back as follows: vector in 7:0, kind in 10:8, logical mode in 11, pending in 12, level in 14, trigger in 15, shorthand in 19:18. Bits 13, 17:16 and 31:20 read as zero. The upper word returns the destination in 31:24 and zero below it.
- R3: A write to the lower word (offset 0x300) while idle sets the pending bit on the next cycle. In that same cycle it drives `req_valid` for exactly one cycle, together with the kind, vector, level and trigger.
- R4: Pending stays set until every target has acknowledged. Acks from non-targets do not count. Pending clears on the cycle after the last target ack.
- R5: A lower-word write while pending is ignored. The stored fields are unchanged and no further pulse is produced.
- R6: A write to the upper word (offset 0x310) updates only the destination. It starts no send.
- R7: With shorthand 00 and physical mode (bit 11 = 0), the core whose 8-bit physical ID equals the destination is targeted. Destination 0xFF targets every core.
- R8: With shorthand 00 and logical mode (bit 11 = 1), every core whose logical ID shares a set bit with the destination is targeted.
- R9: Shorthand 01 targets only the sender. Shorthand 10 targets all cores. Shorthand 11 targets all cores except the sender. The destination is not used in any of these three cases.
- R10: Kind 001 (lowest priority) targets exactly one core: the addressed core with the smallest priority input. A tie goes to the lowest core index.
- R11: Kinds 011 and 111 (reserved), and any send that resolves to no core, produce no pulse. Pending is then set for exactly one cycle.
- R12: For kinds 100 (NMI), 010 (SMI) and 101 (INIT), the driven vector is 0x00 whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register offset for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| self_idx | input | 3 | Index of the sending core |
| phys_ids | input | NCORES*8 | Physical ID of each core |
| log_ids | input | NCORES*8 | Logical ID of each core |
| core_prio | input | NCORES*4 | Current priority of each core |
| req_valid | output | NCORES | One-cycle request pulse per target core |
| req_type | output | 3 | Message kind code |
| req_vector | output | 8 | Vector delivered with the request |
| req_level | output | 1 | Level flag of the message |
| req_trigger | output | 1 | Trigger mode of the message |
| ack | input | NCORES | Per-core delivery acknowledge |

## Verification
The bench targets these failure modes:
- Acks arriving from cores that were not targeted. A design that counted them would drop pending too early.
- A second lower-word write while a send is outstanding. A design that did not block it would overwrite the vector or pulse twice.
- Ties in lowest-priority arbitration. A design with a non-strict compare would pick the higher-indexed core.
- Reserved kinds and destinations that match nothing. A design that mishandled them would hang with pending set forever, or emit an empty pulse.
- The all-but-self shorthand. A design that got it wrong would also interrupt the sender.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

   typedef enum logic [2:0] {
      MT_FIXED  = 3'd0,
      MT_LOWEST = 3'd1,
      MT_SMI    = 3'd2,
      MT_RSV3   = 3'd3,
      MT_NMI    = 3'd4,
      MT_INIT   = 3'd5,
      MT_START  = 3'd6,
      MT_RSV7   = 3'd7
   } msg_type_e;

   typedef enum logic [1:0] {
      SH_NONE   = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } shorthand_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_WAIT = 2'd2
   } disp_state_e;

   typedef struct packed {
      shorthand_e sh;
      logic       trig;
      logic       level;
      logic       logical;
      msg_type_e  mtype;
      logic [7:0] vec;
   } cmd_t;

endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
   import ipi_pkg::*;
#(
   parameter int          ADDR_W = 12,
   parameter int          DEST_W = 8,
   parameter logic [11:0] LO_OFF = 12'h300,
   parameter logic [11:0] HI_OFF = 12'h310
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wr_data,
   input  logic              pending,
   output cmd_t              cmd,
   output logic [DEST_W-1:0] dest,
   output logic              launch,
   output logic [31:0]       rd_data
);

   localparam int PAD_HI = 32 - DEST_W;

   logic lo_sel, hi_sel;
   assign lo_sel = (addr == ADDR_W'(LO_OFF));
   assign hi_sel = (addr == ADDR_W'(HI_OFF));
   assign launch = wr_en && lo_sel && !pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd  <= '0;
         dest <= '0;
      end else begin
         if (launch) begin
            cmd.vec     <= wr_data[7:0];
            cmd.mtype   <= msg_type_e'(wr_data[10:8]);
            cmd.logical <= wr_data[11];
            cmd.level   <= wr_data[14];
            cmd.trig    <= wr_data[15];
            cmd.sh      <= shorthand_e'(wr_data[19:18]);
         end
         if (wr_en && hi_sel)
            dest <= wr_data[31:PAD_HI];
      end
   end

   always_comb begin
      rd_data = '0;
      if (lo_sel)
         rd_data = {12'd0, cmd.sh, 2'b00, cmd.trig, cmd.level, 1'b0,
                    pending, cmd.logical, cmd.mtype, cmd.vec};
      else if (hi_sel)
         rd_data = {dest, {PAD_HI{1'b0}}};
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_data[31:20], wr_data[17:16], wr_data[13]};

   // R5: a write to the lower word while busy leaves the command untouched
   assert_locked_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lo_sel && pending) |=> $stable(cmd));

   // R6: an upper-word write never starts a send
   assert_hi_no_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hi_sel) |-> !launch);

endmodule

// File: rtl/ipi_target_resolve.sv
module ipi_target_resolve
   import ipi_pkg::*;
#(
   parameter int NCORES = 8,
   parameter int ID_W   = 8,
   parameter int IDX_W  = 3
) (
   input  logic [ID_W-1:0]        dest,
   input  logic                   logical,
   input  shorthand_e             sh,
   input  logic [IDX_W-1:0]       self_idx,
   input  logic [NCORES*ID_W-1:0] phys_ids,
   input  logic [NCORES*ID_W-1:0] log_ids,
   output logic [NCORES-1:0]      mask
);

   localparam logic [ID_W-1:0]   BCAST   = {ID_W{1'b1}};
   localparam logic [NCORES-1:0] ONE_HOT = {{(NCORES-1){1'b0}}, 1'b1};

   logic [NCORES-1:0] addr_hit;
   logic [NCORES-1:0] self_mask;

   for (genvar i = 0; i < NCORES; i++) begin : g_core
      logic [ID_W-1:0] pid, lid;
      logic            phys_hit, log_hit;
      assign pid      = phys_ids[i*ID_W +: ID_W];
      assign lid      = log_ids[i*ID_W +: ID_W];
      assign phys_hit = (dest == BCAST) || (dest == pid);
      assign log_hit  = |(dest & lid);
      assign addr_hit[i] = logical ? log_hit : phys_hit;
   end

   assign self_mask = ONE_HOT << self_idx;

   always_comb begin
      unique case (sh)
         SH_SELF:   mask = self_mask;
         SH_ALL:    mask = '1;
         SH_OTHERS: mask = ~self_mask;
         default:   mask = addr_hit;
      endcase
   end

endmodule

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick #(
   parameter int NCORES = 8,
   parameter int PRIO_W = 4
) (
   input  logic [NCORES-1:0]        cand,
   input  logic [NCORES*PRIO_W-1:0] prio,
   output logic [NCORES-1:0]        pick
);

   logic [PRIO_W-1:0] best_prio;
   logic              found;

   always_comb begin
      pick      = '0;
      best_prio = '1;
      found     = 1'b0;
      for (int i = 0; i < NCORES; i++) begin
         // strict compare keeps the lower index on a tie
         if (cand[i] && (!found || prio[i*PRIO_W +: PRIO_W] < best_prio)) begin
            pick      = '0;
            pick[i]   = 1'b1;
            best_prio = prio[i*PRIO_W +: PRIO_W];
            found     = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
   import ipi_pkg::*;
#(
   parameter int          NCORES    = 8,
   parameter int          ID_W      = 8,
   parameter int          PRIO_W    = 4,
   parameter int          ADDR_W    = 12,
   parameter logic [11:0] LO_OFF    = 12'h300,
   parameter logic [11:0] HI_OFF    = 12'h310,
   parameter bit          LOWEST_EN = 1'b1,
   localparam int         IDX_W     = (NCORES > 1) ? $clog2(NCORES) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [31:0]              wr_data,
   output logic [31:0]              rd_data,
   input  logic [IDX_W-1:0]         self_idx,
   input  logic [NCORES*ID_W-1:0]   phys_ids,
   input  logic [NCORES*ID_W-1:0]   log_ids,
   input  logic [NCORES*PRIO_W-1:0] core_prio,
   output logic [NCORES-1:0]        req_valid,
   output logic [2:0]               req_type,
   output logic [7:0]               req_vector,
   output logic                     req_level,
   output logic                     req_trigger,
   input  logic [NCORES-1:0]        ack
);

   if (NCORES < 2)      begin : g_bad_ncores  $error("NCORES must be at least 2"); end
   if (PRIO_W < 1)      begin : g_bad_prio    $error("PRIO_W must be positive"); end
   if (ID_W > 24)       begin : g_bad_id      $error("ID_W must fit the upper word"); end
   if (LO_OFF == HI_OFF) begin : g_bad_offs   $error("word offsets must differ"); end

   disp_state_e       state;
   logic              pending;
   logic              launch;
   cmd_t              cmd;
   logic [ID_W-1:0]   dest;
   logic [NCORES-1:0] resolved, picked, eff_mask, outstanding, still_open;
   logic              reserved, drop, zero_vec;

   assign pending = (state != ST_IDLE);

   ipi_cmd_regs #(
      .ADDR_W (ADDR_W), .DEST_W (ID_W), .LO_OFF (LO_OFF), .HI_OFF (HI_OFF)
   ) regs_i (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr),
      .wr_data (wr_data), .pending (pending), .cmd (cmd), .dest (dest),
      .launch (launch), .rd_data (rd_data)
   );

   ipi_target_resolve #(
      .NCORES (NCORES), .ID_W (ID_W), .IDX_W (IDX_W)
   ) resolve_i (
      .dest (dest), .logical (cmd.logical), .sh (cmd.sh), .self_idx (self_idx),
      .phys_ids (phys_ids), .log_ids (log_ids), .mask (resolved)
   );

   if (LOWEST_EN) begin : g_lowest
      ipi_lowest_pick #(.NCORES (NCORES), .PRIO_W (PRIO_W)) pick_i (
         .cand (resolved), .prio (core_prio), .pick (picked)
      );
   end else begin : g_no_lowest
      logic unused_prio;
      assign unused_prio = ^core_prio;
      assign picked      = resolved;
   end

   assign reserved = (cmd.mtype == MT_RSV3) || (cmd.mtype == MT_RSV7);
   assign eff_mask = (cmd.mtype == MT_LOWEST) ? picked : resolved;
   assign drop     = reserved || (eff_mask == '0);
   assign zero_vec = (cmd.mtype == MT_NMI) || (cmd.mtype == MT_SMI) ||
                     (cmd.mtype == MT_INIT);
   assign still_open = outstanding & ~ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         outstanding <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (launch) state <= ST_SEND;
            ST_SEND: begin
               if (drop) begin
                  state <= ST_IDLE;
               end else begin
                  outstanding <= eff_mask;
                  state       <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               outstanding <= still_open;
               if (still_open == '0) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_valid   = (state == ST_SEND && !drop) ? eff_mask : '0;
   assign req_type    = cmd.mtype;
   assign req_vector  = zero_vec ? 8'h00 : cmd.vec;
   assign req_level   = cmd.level;
   assign req_trigger = cmd.trig;

   // R3: a pulse lasts one cycle and a launch raises pending
   assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_valid) |=> (req_valid == '0));
   assert_pending_after_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> pending);
   // R4: pending holds while any target is still unacknowledged
   assert_hold_until_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && still_open != '0) |=> pending);
   // R9: self shorthand reaches only the sender
   assert_self_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((|req_valid) && cmd.sh == SH_SELF && cmd.mtype != MT_LOWEST) |->
      (req_valid == ({{(NCORES-1){1'b0}}, 1'b1} << self_idx)));
   // R10: lowest priority reaches a single core
   assert_lowest_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((|req_valid) && req_type == MT_LOWEST) |-> $onehot(req_valid));
   // R11: a dropped send leaves pending after one cycle
   assert_drop_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEND && drop) |=> !pending);
   // R12: vector forced to zero for NMI, SMI and INIT
   assert_vec_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ((|req_valid) && (req_type == MT_NMI || req_type == MT_SMI ||
                        req_type == MT_INIT)) |-> (req_vector == 8'h00));

endmodule

// File: tb/ipi_dispatch_tb_top.sv
module ipi_dispatch_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam logic [11:0] LO = 12'h300;
   localparam logic [11:0] HI = 12'h310;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [11:0]   addr = LO;
   logic [31:0]   wr_data = '0;
   logic [31:0]   rd_data;
   logic [2:0]    self_idx = 3'd2;
   logic [N*8-1:0] phys_ids, log_ids;
   logic [N*4-1:0] core_prio;
   logic [N-1:0]  req_valid;
   logic [2:0]    req_type;
   logic [7:0]    req_vector;
   logic          req_level, req_trigger;
   logic [N-1:0]  ack = '0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipi_dispatch dut_i (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr),
      .wr_data (wr_data), .rd_data (rd_data), .self_idx (self_idx),
      .phys_ids (phys_ids), .log_ids (log_ids), .core_prio (core_prio),
      .req_valid (req_valid), .req_type (req_type), .req_vector (req_vector),
      .req_level (req_level), .req_trigger (req_trigger), .ack (ack)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [7:0] vec, input logic [2:0] ty,
                                      input logic lg, input logic lv, input logic tr,
                                      input logic [1:0] sh);
      return {12'd0, sh, 2'b00, tr, lv, 1'b0, 1'b0, lg, ty, vec};
   endfunction

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; addr = LO;
   endtask

   // launch a send and check pulse, pending and completion
   task automatic send(input string tag, input logic [31:0] d, input logic [N-1:0] m,
                       input logic [7:0] vec);
      wr(LO, d);
      chk({tag, " pulse mask"}, 32'(req_valid), 32'(m));
      chk({tag, " R3 pending set"}, 32'(rd_data[12]), 32'd1);
      if (m != '0) begin
         chk({tag, " R3 type"}, 32'(req_type), 32'(d[10:8]));
         chk({tag, " vector"}, 32'(req_vector), 32'(vec));
      end
      @(negedge clk);
      chk({tag, " R3 single pulse"}, 32'(req_valid), 32'd0);
      if (m == '0) begin
         chk({tag, " R11 pending one cycle"}, 32'(rd_data[12]), 32'd0);
      end else begin
         chk({tag, " R4 pending held"}, 32'(rd_data[12]), 32'd1);
         ack = m;
         @(negedge clk);
         ack = '0;
         chk({tag, " R4 pending cleared"}, 32'(rd_data[12]), 32'd0);
      end
   endtask

   task automatic t_reset();
      addr = LO; #1;
      chk("R1 low word", rd_data, 32'd0);
      addr = HI; #1;
      chk("R1 high word", rd_data, 32'd0);
      addr = LO;
      chk("R1 no request", 32'(req_valid), 32'd0);
   endtask

   task automatic t_high();
      wr(HI, 32'h13AB_CDEF);
      chk("R6 no pulse", 32'(req_valid), 32'd0);
      chk("R6 no pending", 32'(rd_data[12]), 32'd0);
      addr = HI; #1;
      chk("R6 R2 high readback", rd_data, 32'h1300_0000);
      addr = LO;
   endtask

   task automatic t_fixed();
      // garbage in bits 31:20, 17:16, 13; shorthand 00, level and trigger set
      wr(LO, 32'hFFF3_E041);
      chk("R7 phys target", 32'(req_valid), 32'h08);
      chk("R3 level", 32'(req_level), 32'd1);
      chk("R3 trigger", 32'(req_trigger), 32'd1);
      chk("R2 R3 readback pending", rd_data, 32'h0000_D041);
      @(negedge clk);
      wr(LO, mk(8'h99, 3'd0, 1'b0, 1'b0, 1'b0, 2'b00));
      chk("R5 no new pulse", 32'(req_valid), 32'd0);
      chk("R5 fields kept", rd_data, 32'h0000_D041);
      ack = 8'h01;
      @(negedge clk);
      ack = '0;
      chk("R4 foreign ack ignored", 32'(rd_data[12]), 32'd1);
      ack = 8'h08;
      @(negedge clk);
      ack = '0;
      chk("R4 cleared after target ack", rd_data, 32'h0000_C041);
      chk("R5 no late pulse", 32'(req_valid), 32'd0);
   endtask

   task automatic t_modes();
      wr(HI, 32'hFF00_0000);
      send("R7 broadcast", mk(8'h20, 3'd0, 1'b0, 1'b0, 1'b0, 2'b00), 8'hFF, 8'h20);
      wr(HI, 32'h0500_0000);
      send("R8 logical", mk(8'h21, 3'd0, 1'b1, 1'b0, 1'b0, 2'b00), 8'h05, 8'h21);
      send("R9 self", mk(8'h22, 3'd6, 1'b0, 1'b0, 1'b0, 2'b01), 8'h04, 8'h22);
      send("R9 all R12 nmi", mk(8'h77, 3'd4, 1'b0, 1'b0, 1'b0, 2'b10), 8'hFF, 8'h00);
      send("R9 others R12 init", mk(8'h33, 3'd5, 1'b0, 1'b0, 1'b0, 2'b11), 8'hFB, 8'h00);
      send("R12 smi", mk(8'h44, 3'd2, 1'b1, 1'b0, 1'b0, 2'b00), 8'h05, 8'h00);
   endtask

   task automatic t_lowest();
      wr(HI, 32'hF000_0000);
      send("R10 lowest logical", mk(8'h50, 3'd1, 1'b1, 1'b0, 1'b0, 2'b00), 8'h20, 8'h50);
      wr(HI, 32'h2800_0000);
      send("R10 tie low index", mk(8'h51, 3'd1, 1'b1, 1'b0, 1'b0, 2'b00), 8'h08, 8'h51);
      wr(HI, 32'hFF00_0000);
      send("R10 broadcast pick", mk(8'h52, 3'd1, 1'b0, 1'b0, 1'b0, 2'b00), 8'h08, 8'h52);
   endtask

   task automatic t_drop();
      wr(HI, 32'h1300_0000);
      send("R11 reserved 3", mk(8'h60, 3'd3, 1'b0, 1'b0, 1'b0, 2'b00), 8'h00, 8'h00);
      send("R11 reserved 7", mk(8'h61, 3'd7, 1'b0, 1'b0, 1'b0, 2'b00), 8'h00, 8'h00);
      wr(HI, 32'h5000_0000);
      send("R11 no match", mk(8'h62, 3'd0, 1'b0, 1'b0, 1'b0, 2'b00), 8'h00, 8'h00);
      send("R11 R7 after drop", mk(8'h63, 3'd0, 1'b0, 1'b0, 1'b0, 2'b00), 8'h00, 8'h00);
   endtask

   initial begin
      // core i: physical ID 0x10+i, logical ID one-hot bit i
      for (int i = 0; i < N; i++) begin
         phys_ids[i*8 +: 8] = 8'(8'h10 + i);
         log_ids[i*8 +: 8]  = 8'(1 << i);
      end
      core_prio = {4'd8, 4'd2, 4'd1, 4'd9, 4'd1, 4'd5, 4'd3, 4'd7};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_high();
      t_fixed();
      t_modes();
      t_lowest();
      t_drop();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule